// File: doc/BRIEF.md
# Input Stub Synchronization Validator

This block sits on one input trigger link. Each clock cycle is one bunch crossing, and in each cycle the link delivers one trigger stub carried in two 16-bit frames. A local bunch-crossing counter runs from reset and wraps once per orbit. The block compares the timing markers inside the stub against that counter. It also compares an external bunch-zero pulse from the clock distribution card against the counter's zero position. The stub is then forwarded to the downstream pipeline one cycle later, with its synchronization-error bit set where needed.

A bunch-zero mismatch latches a sticky error state, and every later stub is marked until software clears it. A mismatch in the low bit of the crossing number marks only the stub it arrived with. When invalidation is enabled, a marked stub loses its valid-pattern flag, and an auxiliary quality output drops to zero for it. A saturating counter counts marked stubs. An out-of-sync flag rises once that count exceeds a programmable threshold. A three-register port gives access to the enable bit, the threshold and the counter.

Top module: `stub_sync_validator`

## Requirements
- R1: The local crossing counter is 0 in the first cycle after reset is released, advances by one each cycle, and returns to 0 after ORBIT_LEN-1.
- R2: In every cycle, both the stub's BC0 bit and the external bunch-zero input must be 1 exactly when the local counter is 0. Any disagreement sets SE on that stub and on every later stub until the error counter is cleared.
- R3: The stub's BX0 bit must equal bit 0 of the local counter. A disagreement sets SE on that stub only.
- R4: A stub that arrives with SE=1 is forwarded with SE=1.
- R5: Register 0 bit 0 is the invalidate enable (reset 0). When it is 1, a forwarded stub with SE=1 has VP=0. When it is 0, VP passes unchanged.
- R6: The auxiliary quality output equals the stub's 4-bit quality when the forwarded VP is 1, and 0 otherwise.
- R7: Register 2 holds a CNT_W-bit counter (16 by default). It adds one for each forwarded stub with SE=1, stops at its maximum value, and reads back on the register port.
- R8: The out-of-sync output rises in the same cycle the counter becomes greater than the threshold in register 1 (reset all ones). It stays high until the counter is cleared.
- R9: Any write to register 2 clears the counter, the sticky error state and the out-of-sync output. The clear takes priority over an increment or a sticky set in the same cycle.
- R10: Frame A holds VP[15], quality[14:11], chamber ID[10:7] and wire group[6:0]. Frame B holds BC0[15], BX0[14], SE[13], bend direction[12], pattern number[11:8] and strip ID[7:0]. Both frames are forwarded one cycle after input. Every field except VP and SE passes unchanged.
- R11: During and straight after reset, the forwarded frames, the auxiliary quality and the out-of-sync output are 0. Register 0 reads 0, register 1 reads all ones, register 2 reads 0, and register 3 always reads 0. Register reads are combinational from the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_frame_a_i | input | 16 | Incoming stub, frame A |
| link_frame_b_i | input | 16 | Incoming stub, frame B |
| ext_bc0_i | input | 1 | Bunch-zero pulse from clock distribution |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data |
| fwd_frame_a_o | output | 16 | Forwarded frame A |
| fwd_frame_b_o | output | 16 | Forwarded frame B |
| aux_qual_o | output | 4 | Quality, zeroed for invalid stubs |
| oos_o | output | 1 | Out-of-sync indication |

## Verification
The bench builds the block with ORBIT_LEN=20 and CNT_W=8. The short orbit lets bunch-zero checks and counter wraps occur many times in a few thousand cycles. The 8-bit counter reaches saturation at 255 in a few hundred cycles of sticky error, so both the hold at the ceiling and a threshold crossing are exercised along with clears made at arbitrary points of the orbit.

// File: rtl/ssv_pkg.sv
package ssv_pkg;

    // Frame A of a stub (bit 15 is the valid-pattern flag)
    typedef struct packed {
        logic       vp;
        logic [3:0] qual;
        logic [3:0] chamber;
        logic [6:0] wire_grp;
    } frame_a_t;

    // Frame B of a stub (timing markers in the upper bits)
    typedef struct packed {
        logic       bc0;
        logic       bx0;
        logic       se;
        logic       bend;
        logic [3:0] pattern;
        logic [7:0] strip;
    } frame_b_t;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_THRESH = 2'd1;
    localparam logic [1:0] ADDR_ERRCNT = 2'd2;

endpackage

// File: rtl/ssv_bx_counter.sv
module ssv_bx_counter #(
    parameter int ORBIT_LEN = 3564,
    parameter int BXN_W     = $clog2(ORBIT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [BXN_W-1:0] bxn_o,
    output logic             at_zero_o
);
    localparam logic [BXN_W-1:0] LAST = BXN_W'(ORBIT_LEN - 1);

    logic [BXN_W-1:0] bxn_d, bxn_q;

    always_comb begin
        bxn_d = (bxn_q == LAST) ? '0 : bxn_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bxn_q <= '0;
        else        bxn_q <= bxn_d;
    end

    assign bxn_o     = bxn_q;
    assign at_zero_o = (bxn_q == '0);
endmodule

// File: rtl/ssv_stub_check.sv
module ssv_stub_check
    import ssv_pkg::*;
(
    input  frame_a_t   frame_a_i,
    input  frame_b_t   frame_b_i,
    input  logic       ext_bc0_i,
    input  logic       at_zero_i,
    input  logic       bxn_lsb_i,
    input  logic       sticky_i,
    input  logic       inv_en_i,
    output frame_a_t   frame_a_o,
    output frame_b_t   frame_b_o,
    output logic [3:0] aux_qual_o,
    output logic       bc0_fault_o,
    output logic       se_o
);
    logic bc0_fault, bx0_fault, se, vp;

    always_comb begin
        bc0_fault = (frame_b_i.bc0 != at_zero_i) | (ext_bc0_i != at_zero_i);
        bx0_fault = (frame_b_i.bx0 != bxn_lsb_i);
        se        = frame_b_i.se | bc0_fault | bx0_fault | sticky_i;
        vp        = frame_a_i.vp & ~(se & inv_en_i);

        frame_a_o    = frame_a_i;
        frame_a_o.vp = vp;
        frame_b_o    = frame_b_i;
        frame_b_o.se = se;
        aux_qual_o   = vp ? frame_a_i.qual : 4'd0;
    end

    assign bc0_fault_o = bc0_fault;
    assign se_o        = se;
endmodule

// File: rtl/ssv_err_tracker.sv
module ssv_err_tracker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bc0_fault_i,
    input  logic             se_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             sticky_o,
    output logic [CNT_W-1:0] err_cnt_o,
    output logic             oos_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             sticky;
        logic [CNT_W-1:0] cnt;
        logic             oos;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else begin
            st_d.sticky = st_q.sticky | bc0_fault_i;
            if (se_i && st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            st_d.oos = st_q.oos | (st_d.cnt > thr_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sticky_o  = st_q.sticky;
    assign err_cnt_o = st_q.cnt;
    assign oos_o     = st_q.oos;
endmodule

// File: rtl/ssv_regs.sv
module ssv_regs
    import ssv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [15:0]      wdata_i,
    output logic             inv_en_o,
    output logic [CNT_W-1:0] thr_o,
    output logic             clear_o
);
    typedef struct packed {
        logic             inv_en;
        logic [CNT_W-1:0] thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && addr_i == ADDR_CTRL)   cfg_d.inv_en = wdata_i[0];
        if (wr_i && addr_i == ADDR_THRESH) cfg_d.thr    = wdata_i[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.inv_en <= 1'b0;
            cfg_q.thr    <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign inv_en_o = cfg_q.inv_en;
    assign thr_o    = cfg_q.thr;
    assign clear_o  = wr_i && (addr_i == ADDR_ERRCNT);
endmodule

// File: rtl/stub_sync_validator.sv
module stub_sync_validator
    import ssv_pkg::*;
#(
    parameter int ORBIT_LEN = 3564,
    parameter int CNT_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] link_frame_a_i,
    input  logic [15:0] link_frame_b_i,
    input  logic        ext_bc0_i,
    input  logic        cfg_wr_i,
    input  logic [1:0]  cfg_addr_i,
    input  logic [15:0] cfg_wdata_i,
    output logic [15:0] cfg_rdata_o,
    output logic [15:0] fwd_frame_a_o,
    output logic [15:0] fwd_frame_b_o,
    output logic [3:0]  aux_qual_o,
    output logic        oos_o
);
    localparam int BXN_W = $clog2(ORBIT_LEN);

    logic [BXN_W-1:0] bxn_q;
    logic             at_zero;
    logic             inv_en_q;
    logic [CNT_W-1:0] thr_q;
    logic             clear;
    logic             sticky_q;
    logic [CNT_W-1:0] err_cnt_q;
    logic             bc0_fault;
    logic             se_now;
    frame_a_t         chk_a;
    frame_b_t         chk_b;
    logic [3:0]       chk_aux;

    ssv_bx_counter #(.ORBIT_LEN(ORBIT_LEN), .BXN_W(BXN_W)) u_bxn (
        .clk       (clk),
        .rst_n     (rst_n),
        .bxn_o     (bxn_q),
        .at_zero_o (at_zero)
    );

    ssv_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cfg_wr_i),
        .addr_i   (cfg_addr_i),
        .wdata_i  (cfg_wdata_i),
        .inv_en_o (inv_en_q),
        .thr_o    (thr_q),
        .clear_o  (clear)
    );

    ssv_stub_check u_check (
        .frame_a_i   (frame_a_t'(link_frame_a_i)),
        .frame_b_i   (frame_b_t'(link_frame_b_i)),
        .ext_bc0_i   (ext_bc0_i),
        .at_zero_i   (at_zero),
        .bxn_lsb_i   (bxn_q[0]),
        .sticky_i    (sticky_q),
        .inv_en_i    (inv_en_q),
        .frame_a_o   (chk_a),
        .frame_b_o   (chk_b),
        .aux_qual_o  (chk_aux),
        .bc0_fault_o (bc0_fault),
        .se_o        (se_now)
    );

    ssv_err_tracker #(.CNT_W(CNT_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .bc0_fault_i (bc0_fault),
        .se_i        (se_now),
        .clear_i     (clear),
        .thr_i       (thr_q),
        .sticky_o    (sticky_q),
        .err_cnt_o   (err_cnt_q),
        .oos_o       (oos_o)
    );

    typedef struct packed {
        frame_a_t   fa;
        frame_b_t   fb;
        logic [3:0] aux;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.fa  = chk_a;
        out_d.fb  = chk_b;
        out_d.aux = chk_aux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign fwd_frame_a_o = out_q.fa;
    assign fwd_frame_b_o = out_q.fb;
    assign aux_qual_o    = out_q.aux;

    always_comb begin
        cfg_rdata_o = '0;
        case (cfg_addr_i)
            ADDR_CTRL:   cfg_rdata_o[0]         = inv_en_q;
            ADDR_THRESH: cfg_rdata_o[CNT_W-1:0] = thr_q;
            ADDR_ERRCNT: cfg_rdata_o[CNT_W-1:0] = err_cnt_q;
            default:     cfg_rdata_o            = '0;
        endcase
    end
endmodule

// File: rtl/ssv_checker.sv
module ssv_checker #(
    parameter int ORBIT_LEN = 3564,
    parameter int CNT_W     = 16,
    parameter int BXN_W     = $clog2(ORBIT_LEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      in_b,
    input logic             wr,
    input logic [1:0]       addr,
    input logic [15:0]      out_a,
    input logic [15:0]      out_b,
    input logic [3:0]       aux,
    input logic             oos,
    input logic [BXN_W-1:0] bxn,
    input logic             inv_en,
    input logic [CNT_W-1:0] err_cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    logic clr;
    assign clr = wr && (addr == 2'd2);

    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (bxn == BXN_W'(ORBIT_LEN - 1)) |=> (bxn == '0));
    a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
        bxn < BXN_W'(ORBIT_LEN));
    a_r3_bx0_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (in_b[14] != bxn[0]) |=> out_b[13]);
    a_r4_se_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_b[13] |=> out_b[13]);
    a_r5_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_b[13] && inv_en) |=> !out_a[15]);
    a_r6_aux_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_a[15] |-> (aux == 4'd0));
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == CMAX && !clr) |=> (err_cnt == CMAX));
    a_r8_oos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (oos && !clr) |=> oos);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_cnt == '0 && !oos));
endmodule

bind stub_sync_validator ssv_checker #(.ORBIT_LEN(ORBIT_LEN), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_b    (link_frame_b_i),
    .wr      (cfg_wr_i),
    .addr    (cfg_addr_i),
    .out_a   (fwd_frame_a_o),
    .out_b   (fwd_frame_b_o),
    .aux     (aux_qual_o),
    .oos     (oos_o),
    .bxn     (bxn_q),
    .inv_en  (inv_en_q),
    .err_cnt (err_cnt_q)
);

// File: tb/stub_sync_validator_tb.sv
module stub_sync_validator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ORB  = 20;
    localparam int CW   = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fa_i = '0, fb_i = '0, wdata = '0;
    logic        ebc0 = 1'b0, wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] rdata, fa_o, fb_o;
    logic [3:0]  aux;
    logic        oos;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model state
    int m_bxn = 0, m_cnt = 0, m_thr = CMAX;
    bit m_sticky = 0, m_oos = 0, m_en = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stub_sync_validator #(.ORBIT_LEN(ORB), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .link_frame_a_i(fa_i), .link_frame_b_i(fb_i), .ext_bc0_i(ebc0),
        .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
        .fwd_frame_a_o(fa_o), .fwd_frame_b_o(fb_o), .aux_qual_o(aux), .oos_o(oos)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int rd_model(input logic [1:0] a);
        case (a)
            2'd0: return int'(m_en);
            2'd1: return m_thr;
            2'd2: return m_cnt;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] rnd_a();
        return 16'($urandom);
    endfunction

    function automatic logic [15:0] good_b(input int bxn);
        logic [15:0] b;
        b = 16'($urandom);
        b[15] = (bxn == 0);
        b[14] = 1'(bxn % 2);
        b[13] = 1'b0;
        return b;
    endfunction

    // Called at a falling edge: drives, predicts, checks after the rising edge.
    task automatic step(input logic [15:0] a, input logic [15:0] b, input logic e,
                        input logic w, input logic [1:0] ad, input logic [15:0] wd,
                        input bit chk_rd, input string req);
        bit at0, bc0f, bx0f, se, vp, clr;
        logic [15:0] ea, eb;
        logic [3:0] eaux;
        int ncnt;
        fa_i = a; fb_i = b; ebc0 = e; wr = w; addr = ad; wdata = wd;
        at0  = (m_bxn == 0);
        bc0f = (b[15] != at0) || (e != at0);
        bx0f = (b[14] != 1'(m_bxn % 2));
        se   = b[13] | bc0f | bx0f | m_sticky;
        vp   = a[15] & ~(se & m_en);
        ea   = {vp, a[14:0]};
        eb   = {b[15:14], se, b[12:0]};
        eaux = vp ? a[14:11] : 4'd0;
        clr  = w && ad == 2'd2;
        @(posedge clk);
        #1;
        chk(fa_o == ea, {req, " frameA"}, fa_o, ea);
        chk(fb_o == eb, {req, " frameB"}, fb_o, eb);
        chk(aux == eaux, {req, " R6 aux"}, aux, eaux);
        if (clr) begin
            m_sticky = 0; m_cnt = 0; m_oos = 0;
        end else begin
            m_sticky = m_sticky | bc0f;
            ncnt = (se && m_cnt != CMAX) ? m_cnt + 1 : m_cnt;
            m_oos = m_oos | (ncnt > m_thr);
            m_cnt = ncnt;
        end
        if (w && ad == 2'd0) m_en = wd[0];
        if (w && ad == 2'd1) m_thr = int'(wd[CW-1:0]);
        m_bxn = (m_bxn == ORB - 1) ? 0 : m_bxn + 1;
        chk(oos == m_oos, {req, " R8 oos"}, oos, m_oos);
        if (chk_rd) chk(rdata == 16'(rd_model(ad)), {req, " R7 readback"}, rdata, rd_model(ad));
        @(negedge clk);
    endtask

    task automatic clean(input int n, input string req);
        for (int i = 0; i < n; i++) step(rnd_a(), good_b(m_bxn), m_bxn == 0, 0, 2'd2, 0, 1, req);
    endtask

    task automatic wreg(input logic [1:0] ad, input logic [15:0] wd, input string req);
        step(rnd_a(), good_b(m_bxn), m_bxn == 0, 1, ad, wd, 1, req);
    endtask

    task automatic rreg(input logic [1:0] ad, input string req);
        step(rnd_a(), good_b(m_bxn), m_bxn == 0, 0, ad, 0, 1, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] b;
        int r;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk(fa_o == 0 && fb_o == 0, "R11 reset frames", fb_o, 0);
        chk(aux == 0 && oos == 0, "R11 reset aux/oos", {aux, oos}, 0);
        addr = 2'd1; #1; chk(rdata == 16'(CMAX), "R11 reset threshold", rdata, CMAX);
        addr = 2'd0; #1; chk(rdata == 0, "R11 reset ctrl", rdata, 0);
        addr = 2'd3; #1; chk(rdata == 0, "R11 reg3", rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1, R10: clean orbits, markers line up, no errors
        clean(2 * ORB + 3, "R1 R10 clean");
        // R5 enable invalidate; R4 incoming SE
        wreg(2'd0, 16'h1, "R5 enable");
        b = good_b(m_bxn); b[13] = 1;
        step(16'h8000 | rnd_a(), b, m_bxn == 0, 0, 2'd2, 0, 1, "R4 R5 se in");
        clean(2, "R4 after");
        // R3 single BX0 error
        b = good_b(m_bxn); b[14] = ~b[14];
        step(16'hF000 | rnd_a(), b, m_bxn == 0, 0, 2'd2, 0, 1, "R3 bx0 err");
        clean(3, "R3 next clean");
        // R8 threshold, R9 clear, R2 stream BC0 error
        wreg(2'd1, 16'd3, "R8 thr");
        wreg(2'd2, 16'd0, "R9 clear");
        while (m_bxn == 0) clean(1, "R2 align");
        b = good_b(m_bxn); b[15] = 1;
        step(rnd_a(), b, 0, 0, 2'd2, 0, 1, "R2 stream bc0");
        clean(8, "R2 sticky R8");
        wreg(2'd2, 16'd0, "R9 clear sticky");
        clean(ORB, "R9 after clear");
        // R2 external BC0 missing
        while (m_bxn != 0) clean(1, "R2 align");
        step(rnd_a(), good_b(0), 0, 0, 2'd2, 0, 1, "R2 ext bc0");
        // R5 disabled: VP survives
        wreg(2'd0, 16'h0, "R5 disable");
        clean(5, "R5 vp kept");
        // R7 saturation, R9 clear priority
        clean(300, "R7 saturate");
        b = good_b(m_bxn); b[14] = ~b[14];
        step(rnd_a(), b, m_bxn == 0, 1, 2'd2, 0, 1, "R9 clear wins");
        clean(5, "R9 post");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            b = good_b(m_bxn);
            r = int'($urandom % 100);
            if (r < 2) b[14] = ~b[14];
            else if (r < 3) b[15] = ~b[15];
            else if (r < 6) b[13] = 1;
            r = int'($urandom % 100);
            if (r < 2)      step(rnd_a(), b, m_bxn == 0, 1, 2'd2, 0, 1, "R9 rnd clear");
            else if (r < 3) step(rnd_a(), b, m_bxn == 0, 1, 2'd1, 16'($urandom % 40), 1, "R8 rnd thr");
            else if (r < 5) step(rnd_a(), b, m_bxn == 0, 1, 2'd0, 16'($urandom), 1, "R5 rnd ctrl");
            else if (r < 6) step(rnd_a(), b, m_bxn == 0 ? 1'b0 : 1'b1, 0, 2'd2, 0, 1, "R2 rnd ext");
            else            step(rnd_a(), b, m_bxn == 0, 0, 2'(r % 4), 0, 1, "R7 rnd");
        end
        rreg(2'd2, "R7 final");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule